// File: doc/BRIEF.md
# AXI4-Lite Single-Master Address Router

This block sits between one AXI4-Lite master and three AXI4-Lite slaves. It looks at the address of every read and every write and sends the transaction to the one slave whose window holds that address. The map is fixed and the windows are not the same size. Target 0 covers 0x4000_0000..0x4000_0FFF and target 1 covers 0x4000_1000..0x4000_1FFF; these are 4 KB each. Target 2 covers 0x4001_0000..0x4001_FFFF, which is 64 KB. An address outside all three windows never reaches a slave. The router answers it by itself with a decode-error code.

The read path and the write path are separate, and each holds at most one transaction at a time. When a master-side address or data beat is accepted, it is captured in a register and then offered to the chosen slave with its own VALID/READY handshake. The slave's response code, and for a read its data, go back to the master unchanged. Write data may come before, after or together with its address. It is held back from every slave until the address has picked the target.

Top module: `lite_fanout_xbar`

## Requirements
- R1: An address in [0x4000_0000, 0x4000_0FFF] goes to target 0, one in [0x4000_1000, 0x4000_1FFF] to target 1, and one in [0x4001_0000, 0x4001_FFFF] to target 2. The slave receives the address unchanged.
- R2: A write to an address outside the three windows raises no slave VALID on the write-address or write-data channel. It completes with bresp = 2'b11.
- R3: A read from an address outside the three windows raises no slave arvalid. It completes with rresp = 2'b11 and rdata = 0.
- R4: The write address and write data are accepted in either order or in the same cycle. Data, strobes and wvalid reach only the decoded slave, and never before the write address has been accepted.
- R5: The bresp, rresp and rdata from the selected slave reach the master unchanged.
- R6: From the acceptance of a write address until its response handshake, awready stays low. From the acceptance of write data until that same handshake, wready stays low.
- R7: From the acceptance of a read address until its read-data handshake, arready stays low.
- R8: A slave-side VALID that is not met by READY stays high in the next cycle, with an unchanged payload.
- R9: A read and a write can be in progress at the same time without affecting each other's routing or results.
- R10: A synchronous active-low reset drops every VALID output and clears any half-finished transaction. After reset, awready, wready and arready are high.
- R11: On each slave-side request channel, at most one of the three VALID bits is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_awaddr | input | 32 | Master write address |
| m_awvalid | input | 1 | Master write address valid |
| m_awready | output | 1 | Write address accepted |
| m_wdata | input | 32 | Master write data |
| m_wstrb | input | 4 | Master write byte strobes |
| m_wvalid | input | 1 | Master write data valid |
| m_wready | output | 1 | Write data accepted |
| m_bresp | output | 2 | Write response code to master |
| m_bvalid | output | 1 | Write response valid |
| m_bready | input | 1 | Master ready for write response |
| m_araddr | input | 32 | Master read address |
| m_arvalid | input | 1 | Master read address valid |
| m_arready | output | 1 | Read address accepted |
| m_rdata | output | 32 | Read data to master |
| m_rresp | output | 2 | Read response code to master |
| m_rvalid | output | 1 | Read data valid |
| m_rready | input | 1 | Master ready for read data |
| s_awaddr | output | 96 | Write address per slave, slave i at bits [32i+31:32i] |
| s_awvalid | output | 3 | Write address valid, one bit per slave |
| s_awready | input | 3 | Write address ready per slave |
| s_wdata | output | 96 | Write data per slave |
| s_wstrb | output | 12 | Write strobes per slave, 4 bits each |
| s_wvalid | output | 3 | Write data valid per slave |
| s_wready | input | 3 | Write data ready per slave |
| s_bresp | input | 6 | Write response per slave, 2 bits each |
| s_bvalid | input | 3 | Write response valid per slave |
| s_bready | output | 3 | Write response ready per slave |
| s_araddr | output | 96 | Read address per slave |
| s_arvalid | output | 3 | Read address valid per slave |
| s_arready | input | 3 | Read address ready per slave |
| s_rdata | input | 96 | Read data per slave |
| s_rresp | input | 6 | Read response per slave, 2 bits each |
| s_rvalid | input | 3 | Read data valid per slave |
| s_rready | output | 3 | Read data ready per slave |

## Verification
Two kinds of event can land in the same cycle. One is a write-address acceptance together with a write-data acceptance. The other is a write transaction in progress while a read transaction is in progress. To provoke the first, the bench offers AW and W together on the same negative edge and also in both staggered orders. To provoke the second, it forks a write and a read on random addresses while the slave models stall READY at random. Each outcome is judged by the response code and data the master receives and by the per-slave handshake tallies kept in the slave models. These are compared with values the bench works out from the address map on its own.

// File: rtl/lite_xbar_pkg.sv
package lite_xbar_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int STRB_W  = DATA_W / 8;
  localparam int RESP_W  = 2;
  localparam int NUM_TGT = 3;
  localparam int TGT_W   = $clog2(NUM_TGT + 1);

  typedef logic [TGT_W-1:0] tgt_t;
  localparam tgt_t TGT_NONE = tgt_t'(NUM_TGT);

  localparam logic [RESP_W-1:0] RESP_DECERR = 2'b11;

  localparam logic [ADDR_W-1:0] TGT_BASE [NUM_TGT] =
    '{32'h4000_0000, 32'h4000_1000, 32'h4001_0000};
  localparam int TGT_SPAN_LOG2 [NUM_TGT] = '{12, 12, 16};

  // Aligned window test: upper bits above the span must match the base.
  function automatic logic window_hit(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base,
                                      input int span_log2);
    return (addr >> span_log2) == (base >> span_log2);
  endfunction

  function automatic tgt_t decode_target(input logic [ADDR_W-1:0] addr);
    tgt_t t;
    t = TGT_NONE;
    for (int i = NUM_TGT - 1; i >= 0; i--) begin
      if (window_hit(addr, TGT_BASE[i], TGT_SPAN_LOG2[i])) t = tgt_t'(i);
    end
    return t;
  endfunction
endpackage

// File: rtl/lite_addr_decode.sv
module lite_addr_decode
  import lite_xbar_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output tgt_t              tgt,
  output logic              miss
);
  assign tgt  = decode_target(addr);
  assign miss = (tgt == TGT_NONE);
endmodule

// File: rtl/lite_wr_router.sv
module lite_wr_router
  import lite_xbar_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           m_awaddr,
  input  logic                        m_awvalid,
  output logic                        m_awready,
  input  logic [DATA_W-1:0]           m_wdata,
  input  logic [STRB_W-1:0]           m_wstrb,
  input  logic                        m_wvalid,
  output logic                        m_wready,
  output logic [RESP_W-1:0]           m_bresp,
  output logic                        m_bvalid,
  input  logic                        m_bready,
  output logic [NUM_TGT*ADDR_W-1:0]   s_awaddr,
  output logic [NUM_TGT-1:0]          s_awvalid,
  input  logic [NUM_TGT-1:0]          s_awready,
  output logic [NUM_TGT*DATA_W-1:0]   s_wdata,
  output logic [NUM_TGT*STRB_W-1:0]   s_wstrb,
  output logic [NUM_TGT-1:0]          s_wvalid,
  input  logic [NUM_TGT-1:0]          s_wready,
  input  logic [NUM_TGT*RESP_W-1:0]   s_bresp,
  input  logic [NUM_TGT-1:0]          s_bvalid,
  output logic [NUM_TGT-1:0]          s_bready,
  output logic                        aw_take,
  output logic                        wr_unmapped
);
  logic              aw_got, w_got, aw_fwd, w_fwd;
  tgt_t              sel_q, dec_tgt;
  logic              dec_miss;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;
  logic              w_take, resp_phase, b_done, aw_hs, w_hs;

  lite_addr_decode u_dec (.addr(m_awaddr), .tgt(dec_tgt), .miss(dec_miss));

  assign m_awready   = !aw_got;
  assign m_wready    = !w_got;
  assign aw_take     = m_awvalid && m_awready;
  assign w_take      = m_wvalid && m_wready;
  assign wr_unmapped = aw_got && (sel_q == TGT_NONE);
  assign resp_phase  = wr_unmapped ? w_got : (aw_fwd && w_fwd);
  assign aw_hs       = |(s_awvalid & s_awready);
  assign w_hs        = |(s_wvalid & s_wready);
  assign b_done      = m_bvalid && m_bready;

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
    assign s_awvalid[i] = aw_got && !aw_fwd && (sel_q == tgt_t'(i));
    assign s_wvalid[i]  = aw_got && w_got && !w_fwd && (sel_q == tgt_t'(i));
    assign s_bready[i]  = resp_phase && m_bready && (sel_q == tgt_t'(i));
    assign s_awaddr[i*ADDR_W +: ADDR_W] = addr_q;
    assign s_wdata[i*DATA_W +: DATA_W]  = data_q;
    assign s_wstrb[i*STRB_W +: STRB_W]  = strb_q;
  end

  always_comb begin
    m_bvalid = 1'b0;
    m_bresp  = '0;
    if (resp_phase) begin
      if (wr_unmapped) begin
        m_bvalid = 1'b1;
        m_bresp  = RESP_DECERR;
      end else begin
        for (int i = 0; i < NUM_TGT; i++) begin
          if (sel_q == tgt_t'(i)) begin
            m_bvalid = s_bvalid[i];
            m_bresp  = s_bresp[i*RESP_W +: RESP_W];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_got <= 1'b0;
      w_got  <= 1'b0;
      aw_fwd <= 1'b0;
      w_fwd  <= 1'b0;
      sel_q  <= TGT_NONE;
      addr_q <= '0;
      data_q <= '0;
      strb_q <= '0;
    end else if (b_done) begin
      aw_got <= 1'b0;
      w_got  <= 1'b0;
      aw_fwd <= 1'b0;
      w_fwd  <= 1'b0;
    end else begin
      if (aw_take) begin
        aw_got <= 1'b1;
        addr_q <= m_awaddr;
        sel_q  <= dec_miss ? TGT_NONE : dec_tgt;
      end
      if (w_take) begin
        w_got  <= 1'b1;
        data_q <= m_wdata;
        strb_q <= m_wstrb;
      end
      if (aw_hs) aw_fwd <= 1'b1;
      if (w_hs)  w_fwd  <= 1'b1;
    end
  end
endmodule

// File: rtl/lite_rd_router.sv
module lite_rd_router
  import lite_xbar_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           m_araddr,
  input  logic                        m_arvalid,
  output logic                        m_arready,
  output logic [DATA_W-1:0]           m_rdata,
  output logic [RESP_W-1:0]           m_rresp,
  output logic                        m_rvalid,
  input  logic                        m_rready,
  output logic [NUM_TGT*ADDR_W-1:0]   s_araddr,
  output logic [NUM_TGT-1:0]          s_arvalid,
  input  logic [NUM_TGT-1:0]          s_arready,
  input  logic [NUM_TGT*DATA_W-1:0]   s_rdata,
  input  logic [NUM_TGT*RESP_W-1:0]   s_rresp,
  input  logic [NUM_TGT-1:0]          s_rvalid,
  output logic [NUM_TGT-1:0]          s_rready,
  output logic                        ar_take,
  output logic                        rd_unmapped
);
  logic              ar_got, ar_fwd, ar_hs, resp_phase, r_done, dec_miss;
  tgt_t              sel_q, dec_tgt;
  logic [ADDR_W-1:0] addr_q;

  lite_addr_decode u_dec (.addr(m_araddr), .tgt(dec_tgt), .miss(dec_miss));

  assign m_arready   = !ar_got;
  assign ar_take     = m_arvalid && m_arready;
  assign rd_unmapped = ar_got && (sel_q == TGT_NONE);
  assign resp_phase  = rd_unmapped ? 1'b1 : ar_fwd;
  assign ar_hs       = |(s_arvalid & s_arready);
  assign r_done      = m_rvalid && m_rready;

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
    assign s_arvalid[i] = ar_got && !ar_fwd && (sel_q == tgt_t'(i));
    assign s_rready[i]  = resp_phase && m_rready && (sel_q == tgt_t'(i));
    assign s_araddr[i*ADDR_W +: ADDR_W] = addr_q;
  end

  always_comb begin
    m_rvalid = 1'b0;
    m_rresp  = '0;
    m_rdata  = '0;
    if (ar_got && resp_phase) begin
      if (rd_unmapped) begin
        m_rvalid = 1'b1;
        m_rresp  = RESP_DECERR;
      end else begin
        for (int i = 0; i < NUM_TGT; i++) begin
          if (sel_q == tgt_t'(i)) begin
            m_rvalid = s_rvalid[i];
            m_rresp  = s_rresp[i*RESP_W +: RESP_W];
            m_rdata  = s_rdata[i*DATA_W +: DATA_W];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ar_got <= 1'b0;
      ar_fwd <= 1'b0;
      sel_q  <= TGT_NONE;
      addr_q <= '0;
    end else if (r_done) begin
      ar_got <= 1'b0;
      ar_fwd <= 1'b0;
    end else begin
      if (ar_take) begin
        ar_got <= 1'b1;
        addr_q <= m_araddr;
        sel_q  <= dec_miss ? TGT_NONE : dec_tgt;
      end
      if (ar_hs) ar_fwd <= 1'b1;
    end
  end
endmodule

// File: rtl/lite_fanout_xbar.sv
module lite_fanout_xbar
  import lite_xbar_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           m_awaddr,
  input  logic                        m_awvalid,
  output logic                        m_awready,
  input  logic [DATA_W-1:0]           m_wdata,
  input  logic [STRB_W-1:0]           m_wstrb,
  input  logic                        m_wvalid,
  output logic                        m_wready,
  output logic [RESP_W-1:0]           m_bresp,
  output logic                        m_bvalid,
  input  logic                        m_bready,
  input  logic [ADDR_W-1:0]           m_araddr,
  input  logic                        m_arvalid,
  output logic                        m_arready,
  output logic [DATA_W-1:0]           m_rdata,
  output logic [RESP_W-1:0]           m_rresp,
  output logic                        m_rvalid,
  input  logic                        m_rready,
  output logic [NUM_TGT*ADDR_W-1:0]   s_awaddr,
  output logic [NUM_TGT-1:0]          s_awvalid,
  input  logic [NUM_TGT-1:0]          s_awready,
  output logic [NUM_TGT*DATA_W-1:0]   s_wdata,
  output logic [NUM_TGT*STRB_W-1:0]   s_wstrb,
  output logic [NUM_TGT-1:0]          s_wvalid,
  input  logic [NUM_TGT-1:0]          s_wready,
  input  logic [NUM_TGT*RESP_W-1:0]   s_bresp,
  input  logic [NUM_TGT-1:0]          s_bvalid,
  output logic [NUM_TGT-1:0]          s_bready,
  output logic [NUM_TGT*ADDR_W-1:0]   s_araddr,
  output logic [NUM_TGT-1:0]          s_arvalid,
  input  logic [NUM_TGT-1:0]          s_arready,
  input  logic [NUM_TGT*DATA_W-1:0]   s_rdata,
  input  logic [NUM_TGT*RESP_W-1:0]   s_rresp,
  input  logic [NUM_TGT-1:0]          s_rvalid,
  output logic [NUM_TGT-1:0]          s_rready
);
  // Internal events brought out for the bound checker.
  logic aw_take, ar_take, wr_unmapped, rd_unmapped;

  lite_wr_router u_wr (
    .clk, .rst_n,
    .m_awaddr, .m_awvalid, .m_awready,
    .m_wdata, .m_wstrb, .m_wvalid, .m_wready,
    .m_bresp, .m_bvalid, .m_bready,
    .s_awaddr, .s_awvalid, .s_awready,
    .s_wdata, .s_wstrb, .s_wvalid, .s_wready,
    .s_bresp, .s_bvalid, .s_bready,
    .aw_take, .wr_unmapped
  );

  lite_rd_router u_rd (
    .clk, .rst_n,
    .m_araddr, .m_arvalid, .m_arready,
    .m_rdata, .m_rresp, .m_rvalid, .m_rready,
    .s_araddr, .s_arvalid, .s_arready,
    .s_rdata, .s_rresp, .s_rvalid, .s_rready,
    .ar_take, .rd_unmapped
  );
endmodule

// File: rtl/lite_xbar_checker.sv
module lite_xbar_checker
  import lite_xbar_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      m_awready,
  input logic                      m_wready,
  input logic                      m_bvalid,
  input logic                      m_arready,
  input logic                      m_rvalid,
  input logic [RESP_W-1:0]         m_rresp,
  input logic [DATA_W-1:0]         m_rdata,
  input logic [NUM_TGT*ADDR_W-1:0] s_awaddr,
  input logic [NUM_TGT-1:0]        s_awvalid,
  input logic [NUM_TGT-1:0]        s_awready,
  input logic [NUM_TGT*DATA_W-1:0] s_wdata,
  input logic [NUM_TGT-1:0]        s_wvalid,
  input logic [NUM_TGT-1:0]        s_wready,
  input logic [NUM_TGT*ADDR_W-1:0] s_araddr,
  input logic [NUM_TGT-1:0]        s_arvalid,
  input logic [NUM_TGT-1:0]        s_arready,
  input logic                      wr_unmapped,
  input logic                      rd_unmapped
);
  assert_aw_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_awvalid));
  assert_w_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_wvalid));
  assert_ar_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_arvalid));

  assert_aw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(s_awvalid & ~s_awready)) |=> ($stable(s_awvalid) && $stable(s_awaddr)));
  assert_w_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(s_wvalid & ~s_wready)) |=> ($stable(s_wvalid) && $stable(s_wdata)));
  assert_ar_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(s_arvalid & ~s_arready)) |=> ($stable(s_arvalid) && $stable(s_araddr)));

  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_bvalid |-> (!m_awready && !m_wready));
  assert_rd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> !m_arready);

  assert_wr_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |-> (s_awvalid == '0 && s_wvalid == '0));
  assert_rd_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |-> (s_arvalid == '0));
  assert_rd_decerr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_unmapped && m_rvalid) |-> (m_rresp == RESP_DECERR && m_rdata == '0));

  assert_w_needs_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_wvalid) |-> !m_awready);
endmodule

bind lite_fanout_xbar lite_xbar_checker i_chk (
  .clk(clk), .rst_n(rst_n),
  .m_awready(m_awready), .m_wready(m_wready), .m_bvalid(m_bvalid),
  .m_arready(m_arready), .m_rvalid(m_rvalid), .m_rresp(m_rresp), .m_rdata(m_rdata),
  .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
  .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
  .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
  .wr_unmapped(wr_unmapped), .rd_unmapped(rd_unmapped)
);

// File: tb/test_lite_fanout_xbar.sv
`timescale 1ns/1ps
module test_lite_fanout_xbar;
  localparam int NT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] m_awaddr = '0, m_wdata = '0, m_araddr = '0;
  logic [3:0]  m_wstrb = '0;
  logic m_awvalid = 0, m_wvalid = 0, m_bready = 0, m_arvalid = 0, m_rready = 0;
  logic m_awready, m_wready, m_bvalid, m_arready, m_rvalid;
  logic [1:0]  m_bresp, m_rresp;
  logic [31:0] m_rdata;

  logic [NT*32-1:0] s_awaddr, s_wdata, s_araddr, s_rdata;
  logic [NT*4-1:0]  s_wstrb;
  logic [NT-1:0] s_awvalid, s_wvalid, s_arvalid, s_bready, s_rready;
  logic [NT-1:0] s_awready, s_wready, s_arready, s_bvalid, s_rvalid;
  logic [NT*2-1:0] s_bresp, s_rresp;

  lite_fanout_xbar i_lite_fanout_xbar (.*);

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Bench-side view of the map: inclusive ranges.
  function automatic int exp_target(input logic [31:0] a);
    if (a >= 32'h4000_0000 && a <= 32'h4000_0FFF) return 0;
    if (a >= 32'h4000_1000 && a <= 32'h4000_1FFF) return 1;
    if (a >= 32'h4001_0000 && a <= 32'h4001_FFFF) return 2;
    return 3;
  endfunction
  function automatic logic [1:0] slv_bresp(input int i); return (i == 1) ? 2'b10 : 2'b00; endfunction
  function automatic logic [1:0] slv_rresp(input int i); return (i == 2) ? 2'b10 : 2'b00; endfunction
  function automatic logic [31:0] slv_rdata(input logic [31:0] a, input int i);
    return {a[15:0], a[31:16]} ^ (32'h5A00_0000 + i);
  endfunction

  // Slave models
  logic [NT-1:0] got_aw, got_w, bv, rv;
  logic [31:0] rd_q [NT];
  logic [31:0] last_aw [NT], last_w [NT], last_ar [NT];
  logic [3:0]  last_s [NT];
  int aw_cnt [NT], w_cnt [NT], ar_cnt [NT];

  assign s_bvalid = bv;
  assign s_rvalid = rv;
  for (genvar g = 0; g < NT; g++) begin : g_sl
    assign s_bresp[g*2 +: 2]  = slv_bresp(g);
    assign s_rresp[g*2 +: 2]  = slv_rresp(g);
    assign s_rdata[g*32 +: 32] = rd_q[g];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      got_aw <= '0; got_w <= '0; bv <= '0; rv <= '0;
      s_awready <= '0; s_wready <= '0; s_arready <= '0;
      for (int i = 0; i < NT; i++) begin
        rd_q[i] <= '0; aw_cnt[i] <= 0; w_cnt[i] <= 0; ar_cnt[i] <= 0;
      end
    end else begin
      for (int i = 0; i < NT; i++) begin
        if (s_awvalid[i] && s_awready[i]) begin
          got_aw[i] <= 1'b1; aw_cnt[i] <= aw_cnt[i] + 1; last_aw[i] <= s_awaddr[i*32 +: 32];
        end
        if (s_wvalid[i] && s_wready[i]) begin
          got_w[i] <= 1'b1; w_cnt[i] <= w_cnt[i] + 1;
          last_w[i] <= s_wdata[i*32 +: 32]; last_s[i] <= s_wstrb[i*4 +: 4];
        end
        if (got_aw[i] && got_w[i] && !bv[i]) begin
          bv[i] <= 1'b1; got_aw[i] <= 1'b0; got_w[i] <= 1'b0;
        end
        if (bv[i] && s_bready[i]) bv[i] <= 1'b0;
        if (s_arvalid[i] && s_arready[i]) begin
          rv[i] <= 1'b1; ar_cnt[i] <= ar_cnt[i] + 1;
          last_ar[i] <= s_araddr[i*32 +: 32];
          rd_q[i] <= slv_rdata(s_araddr[i*32 +: 32], i);
        end
        if (rv[i] && s_rready[i]) rv[i] <= 1'b0;
        s_awready[i] <= ($urandom % 3) != 0;
        s_wready[i]  <= ($urandom % 3) != 0;
        s_arready[i] <= ($urandom % 3) != 0;
      end
    end
  end

  // Slave-side stall and exclusivity monitor (R8, R11)
  int mon_viol = 0;
  logic [NT-1:0] p_awv, p_wv, p_arv, p_aws, p_ws, p_ars;
  logic [NT*32-1:0] p_awa, p_wd, p_ara;
  always @(negedge clk) begin
    if (!rst_n) begin
      p_aws <= '0; p_ws <= '0; p_ars <= '0;
    end else begin
      if (!$onehot0(s_awvalid) || !$onehot0(s_wvalid) || !$onehot0(s_arvalid)) mon_viol++;
      if (|p_aws && (s_awvalid != p_awv || s_awaddr != p_awa)) mon_viol++;
      if (|p_ws  && (s_wvalid  != p_wv  || s_wdata  != p_wd))  mon_viol++;
      if (|p_ars && (s_arvalid != p_arv || s_araddr != p_ara)) mon_viol++;
      p_aws <= s_awvalid & ~s_awready; p_ws <= s_wvalid & ~s_wready; p_ars <= s_arvalid & ~s_arready;
      p_awv <= s_awvalid; p_wv <= s_wvalid; p_arv <= s_arvalid;
      p_awa <= s_awaddr; p_wd <= s_wdata; p_ara <= s_araddr;
    end
  end

  task automatic send_aw(input logic [31:0] a);
    @(negedge clk); m_awaddr = a; m_awvalid = 1;
    while (!m_awready) @(negedge clk);
    @(negedge clk); m_awvalid = 0;
  endtask
  task automatic send_w(input logic [31:0] d, input logic [3:0] s);
    @(negedge clk); m_wdata = d; m_wstrb = s; m_wvalid = 1;
    while (!m_wready) @(negedge clk);
    @(negedge clk); m_wvalid = 0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s, input int order);
    int t, c0[NT], ok_cnt;
    logic [1:0] r;
    t = exp_target(a);
    for (int j = 0; j < NT; j++) c0[j] = aw_cnt[j] + w_cnt[j];
    if (order == 0) begin
      send_aw(a);
      if (t < 3) chk(!m_awready, "R6 awready low while write pending", {31'd0, m_awready}, 0);
      send_w(d, s);
    end else if (order == 1) begin
      send_w(d, s);
      repeat (3) @(negedge clk);
      chk(s_wvalid == '0, "R4 data held until address known", {29'd0, s_wvalid}, 0);
      chk(!m_wready, "R6 wready low while write pending", {31'd0, m_wready}, 0);
      send_aw(a);
    end else begin
      fork send_aw(a); send_w(d, s); join
    end
    m_bready = 0;
    repeat ($urandom % 3) @(negedge clk);
    m_bready = 1;
    while (!m_bvalid) @(negedge clk);
    r = m_bresp;
    @(negedge clk); m_bready = 0;
    if (t == 3) chk(r == 2'b11, "R2 unmapped write bresp", {30'd0, r}, 3);
    else        chk(r == slv_bresp(t), "R5 bresp passthrough", {30'd0, r}, {30'd0, slv_bresp(t)});
    ok_cnt = 1;
    for (int j = 0; j < NT; j++)
      if (aw_cnt[j] + w_cnt[j] - c0[j] != ((j == t) ? 2 : 0)) ok_cnt = 0;
    chk(ok_cnt == 1, (t == 3) ? "R2 no slave touched" : "R1 R4 write routed to one slave", a, t);
    if (t < 3) begin
      chk(last_aw[t] == a, "R1 slave write address", last_aw[t], a);
      chk(last_w[t] == d && last_s[t] == s, "R4 slave write data and strobes", last_w[t], d);
    end
  endtask

  task automatic do_read(input logic [31:0] a);
    int t, c0[NT], ok_cnt;
    logic [1:0] r;
    logic [31:0] dt;
    t = exp_target(a);
    for (int j = 0; j < NT; j++) c0[j] = ar_cnt[j];
    @(negedge clk); m_araddr = a; m_arvalid = 1;
    while (!m_arready) @(negedge clk);
    @(negedge clk); m_arvalid = 0;
    chk(!m_arready || m_rvalid == 0, "R7 arready low while read pending", {31'd0, m_arready}, 0);
    m_rready = 0;
    repeat ($urandom % 3) @(negedge clk);
    m_rready = 1;
    while (!m_rvalid) @(negedge clk);
    r = m_rresp; dt = m_rdata;
    @(negedge clk); m_rready = 0;
    if (t == 3) begin
      chk(r == 2'b11, "R3 unmapped read rresp", {30'd0, r}, 3);
      chk(dt == 0, "R3 unmapped read data zero", dt, 0);
    end else begin
      chk(r == slv_rresp(t), "R5 rresp passthrough", {30'd0, r}, {30'd0, slv_rresp(t)});
      chk(dt == slv_rdata(a, t), "R5 rdata passthrough", dt, slv_rdata(a, t));
      chk(last_ar[t] == a, "R1 slave read address", last_ar[t], a);
    end
    ok_cnt = 1;
    for (int j = 0; j < NT; j++) if (ar_cnt[j] - c0[j] != ((j == t) ? 1 : 0)) ok_cnt = 0;
    chk(ok_cnt == 1, (t == 3) ? "R3 no slave touched" : "R1 read routed to one slave", a, t);
  endtask

  function automatic logic [31:0] pick_addr(input int k, input logic [31:0] rnd);
    case (k)
      0: return 32'h4000_0000 | (rnd & 32'h0000_0FFC);
      1: return 32'h4000_1000 | (rnd & 32'h0000_0FFC);
      2: return 32'h4001_0000 | (rnd & 32'h0000_FFFC);
      3: return 32'h4000_2000 | (rnd & 32'h0000_DFFC);
      default: return rnd;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] edges [10];
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(m_awready && m_wready && m_arready, "R10 readies high in reset", {29'd0, m_awready, m_wready, m_arready}, 7);
    chk(!m_bvalid && !m_rvalid && s_awvalid == 0 && s_wvalid == 0 && s_arvalid == 0,
        "R10 valids low in reset", {26'd0, m_bvalid, m_rvalid, s_awvalid == 0, s_wvalid == 0, s_arvalid == 0, 1'b0}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1/R2/R3: window edges
    edges = '{32'h4000_0000, 32'h4000_0FFF, 32'h4000_1000, 32'h4000_1FFF, 32'h4000_2000,
              32'h4001_0000, 32'h4001_FFFF, 32'h4002_0000, 32'h3FFF_FFFC, 32'h4000_FFFC};
    foreach (edges[i]) begin
      do_write(edges[i], 32'hC0DE_0000 + i, 4'hF, i % 3);
      do_read(edges[i]);
    end

    // R10: reset with a write half done
    send_aw(32'h4000_0010);
    repeat (3) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(m_awready && m_wready && s_awvalid == 0 && s_wvalid == 0 && !m_bvalid,
        "R10 pending write cleared", {28'd0, m_awready, m_wready, |s_awvalid, m_bvalid}, 32'hC);
    rst_n = 1;
    repeat (2) @(negedge clk);
    do_write(32'h4000_1004, 32'h1234_5678, 4'h5, 2);

    // Random mix; every other round overlaps a read with the write (R9)
    for (int n = 0; n < 60; n++) begin
      logic [31:0] wa, ra, wd;
      logic [3:0] ws;
      int ord;
      wa = pick_addr($urandom % 5, $urandom);
      ra = pick_addr($urandom % 5, $urandom);
      wd = $urandom; ws = 4'($urandom); ord = $urandom % 3;
      if (n % 2 == 0) begin
        fork do_write(wa, wd, ws, ord); do_read(ra); join
      end else begin
        do_write(wa, wd, ws, ord);
        do_read(ra);
      end
    end

    chk(mon_viol == 0, "R8 R11 slave-side valid hold and exclusivity", mon_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule